// File: doc/BRIEF.md
# Audio Device Control and Clock Status Registers

This block is the control and status register file of an audio device that sits on a serial bus. The host reaches it with single 32-bit quadlet requests: a read, a write, or an atomic compare/swap that acts on the 64-bit owner address. Every request gets a response one cycle later. A read returns one quadlet. A compare/swap returns the full 64-bit value that the owner held before the request.

The block tracks asynchronous device events. These are configuration changes reported by the stream logic, lock changes on the clock sources, and the completion of a clock-select write. When one or more events occur in a cycle, the event register is overwritten with exactly that cycle's event bits. A notification carrying the same word is then pushed toward the current owner address, unless nobody owns the device.

Lock inputs from clock recovery are mirrored live. Slip pulses are held in sticky bits until the status quadlet is read. A bus reset drops ownership and stops streaming.

Top module: `audio_ctl_regs`

## Requirements
- R1: After reset or a bus reset, the owner reads as 0xFFFF_0000_0000_0000, with the upper quadlet at index 0 and the lower quadlet at index 1. After reset, the event register (index 2) reads 0, the clock select (index 3) reads 0x0000020C, and the stream enable (index 4) reads 0.
- R2: A compare/swap (op 2) to index 0 stores the swap value only when the owner equals the compare value. It always returns the previous 64-bit owner value.
- R3: A plain write (op 1) to index 0 or index 1 leaves the owner unchanged.
- R4: In any cycle with at least one event, the event register is overwritten with only that cycle's bits, so earlier bits are dropped. The bit positions are: bit 0 RX configuration change, bit 1 TX configuration change, bit 4 lock change of the selected source, bit 5 clock select accepted, bit 6 lock change of any source.
- R5: Every event cycle produces one notification the next cycle, carrying the event word and the owner address. No notification is pushed while the owner holds the no-owner value.
- R6: The clock select holds the source in bits 7:0 and the rate code in bits 15:8 (code 0 is 32 kHz up to code 6, 192 kHz; 0x0A means no rate). A write of a supported pair reads back unchanged and raises event bit 5.
- R7: A clock select write with an unsupported source stores source 0x0C (the internal clock). A write with an unsupported rate keeps the previous rate. Either write still raises event bit 5. With the default settings, sources 8 to 11 and rate codes above 4 are unsupported.
- R8: Bits 10:0 of the extended status (index 5) show the live lock inputs. Any change on them raises event bit 6. A change on the lock line of the selected source also raises bit 4. Source codes 0 to 3 use lines 0 to 3, and source 2 uses line 2.
- R9: A slip pulse on line n sets bit 16+n of the extended status. That bit stays set until a quadlet read of index 5, which returns the set bit and then clears it. Slips never raise an event.
- R10: A write to index 4 of a nonzero value enables streaming (reads 1), and a write of zero disables it. A bus reset also disables it.
- R11: Writes to the event register and the extended status are ignored. Reads of unmapped indices return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | Bus reset pulse: drops owner, stops streams |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_op_i | input | 2 | 0 read, 1 write, 2 compare/swap |
| req_addr_i | input | 6 | Quadlet index |
| req_wdata_i | input | 32 | Write data |
| req_cmp_i | input | 64 | Compare value for compare/swap |
| req_swap_i | input | 64 | New value for compare/swap |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_rdata_o | output | 32 | Read data |
| rsp_old_o | output | 64 | Owner value before a compare/swap |
| rx_cfg_chg_i | input | 1 | RX configuration change pulse |
| tx_cfg_chg_i | input | 1 | TX configuration change pulse |
| lock_i | input | 11 | Live lock state per clock source |
| slip_i | input | 11 | Slip error pulses per clock source |
| ntf_valid_o | output | 1 | Notification push strobe |
| ntf_word_o | output | 32 | Event word being pushed |
| ntf_addr_o | output | 64 | Destination (owner) address |
| stream_en_o | output | 1 | Streams running |

## Verification
Events are fired first with no owner and then with an owner. The two cases separate event latching from the push gating. Compare/swap is tried with a mismatching compare value and then a matching one, which shows whether the store depends on the comparison. Clock select writes are made with a supported pair, an unsupported source and an unsupported rate, which tells the fallback rules apart. Lock toggles are made on the selected source and on an unrelated line to separate event bits 4 and 6. A slip followed by two reads shows both stickiness and clear-on-read.

// File: rtl/aud_regs_pkg.sv
package aud_regs_pkg;
  parameter int DW       = 32;
  parameter int AW       = 6;
  parameter int OWN_W    = 64;
  parameter int LOCK_W   = 11;
  parameter int SLIP_LSB = 16;
  parameter int FLD_W    = 8;
  parameter int NUM_SRC  = 13;
  parameter int NUM_RATE = 7;

  localparam logic [OWN_W-1:0] NO_OWNER = 64'hFFFF_0000_0000_0000;
  localparam logic [FLD_W-1:0] SRC_INTERNAL = 8'h0C;
  localparam logic [FLD_W-1:0] RATE_RESET   = 8'h02;

  localparam logic [1:0] OP_RD  = 2'd0;
  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_CAS = 2'd2;

  localparam logic [AW-1:0] IDX_OWN_HI = 6'd0;
  localparam logic [AW-1:0] IDX_OWN_LO = 6'd1;
  localparam logic [AW-1:0] IDX_EVENT  = 6'd2;
  localparam logic [AW-1:0] IDX_CLKSEL = 6'd3;
  localparam logic [AW-1:0] IDX_STREAM = 6'd4;
  localparam logic [AW-1:0] IDX_XSTAT  = 6'd5;

  localparam int EV_RX       = 0;
  localparam int EV_TX       = 1;
  localparam int EV_CUR_LOCK = 4;
  localparam int EV_ACCEPT   = 5;
  localparam int EV_ANY_LOCK = 6;

  // Lock line that belongs to a selected source; internal is always locked.
  function automatic logic src_lock(input logic [FLD_W-1:0] src,
                                    input logic [LOCK_W-1:0] lk);
    logic r;
    case (src)
      8'h00: r = lk[0];
      8'h01: r = lk[1];
      8'h02: r = lk[2];
      8'h03: r = lk[3];
      8'h04: r = |lk[3:0];
      8'h05: r = lk[4];
      8'h06: r = lk[5];
      8'h07: r = lk[10];
      8'h08: r = lk[6];
      8'h09: r = lk[7];
      8'h0A: r = lk[8];
      8'h0B: r = lk[9];
      default: r = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/aud_owner_cas.sv
module aud_owner_cas
  import aud_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset_i,
  input  logic             cas_en_i,
  input  logic [OWN_W-1:0] cmp_i,
  input  logic [OWN_W-1:0] swap_i,
  output logic [OWN_W-1:0] owner_o
);
  logic [OWN_W-1:0] owner_q, owner_d;
  logic             owner_ce;

  always_comb begin
    owner_d  = owner_q;
    owner_ce = 1'b0;
    if (bus_reset_i) begin
      owner_d  = NO_OWNER;
      owner_ce = 1'b1;
    end else if (cas_en_i && (owner_q == cmp_i)) begin
      owner_d  = swap_i;
      owner_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        owner_q <= NO_OWNER;
    else if (owner_ce) owner_q <= owner_d;
  end

  assign owner_o = owner_q;

  assert_busrst_owner_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> (owner_o == NO_OWNER));
  assert_cas_miss_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_en_i && !bus_reset_i && (owner_o != cmp_i)) |=> $stable(owner_o));
  assert_owner_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_en_i && !bus_reset_i) |=> $stable(owner_o));
endmodule

// File: rtl/aud_clk_select.sv
module aud_clk_select
  import aud_regs_pkg::*;
#(
  parameter logic [NUM_SRC-1:0]  SRC_CAP  = 13'h10FF,
  parameter logic [NUM_RATE-1:0] RATE_CAP = 7'h1F
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [FLD_W-1:0] wr_src_i,
  input  logic [FLD_W-1:0] wr_rate_i,
  output logic [FLD_W-1:0] src_o,
  output logic [FLD_W-1:0] rate_o
);
  logic [FLD_W-1:0] src_q, src_d, rate_q, rate_d;
  logic             src_ok, rate_ok;

  always_comb begin
    src_ok  = (int'(wr_src_i) < NUM_SRC) && SRC_CAP[wr_src_i[3:0]];
    rate_ok = (int'(wr_rate_i) < NUM_RATE) && RATE_CAP[wr_rate_i[2:0]];
    src_d   = src_ok  ? wr_src_i  : SRC_INTERNAL;
    rate_d  = rate_ok ? wr_rate_i : rate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_INTERNAL;
      rate_q <= RATE_RESET;
    end else if (wr_en_i) begin
      src_q  <= src_d;
      rate_q <= rate_d;
    end
  end

  assign src_o  = src_q;
  assign rate_o = rate_q;

  assert_src_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> ((src_o == $past(wr_src_i)) || (src_o == SRC_INTERNAL)));
  assert_rate_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> ((rate_o == $past(wr_rate_i)) || (rate_o == $past(rate_o))));
endmodule

// File: rtl/aud_ext_status.sv
module aud_ext_status
  import aud_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOCK_W-1:0] lock_i,
  input  logic [LOCK_W-1:0] slip_i,
  input  logic              rd_clr_i,
  output logic [LOCK_W-1:0] lock_o,
  output logic [LOCK_W-1:0] slip_o,
  output logic              any_chg_o
);
  logic [LOCK_W-1:0] lock_q, slip_q, slip_d;

  always_comb begin
    slip_d    = (rd_clr_i ? '0 : slip_q) | slip_i;
    any_chg_o = (lock_i != lock_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      slip_q <= '0;
    end else begin
      lock_q <= lock_i;
      slip_q <= slip_d;
    end
  end

  assign lock_o = lock_q;
  assign slip_o = slip_q;

  assert_slip_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr_i |=> ((slip_o & $past(slip_o)) == $past(slip_o)));
  assert_slip_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|slip_i) |=> ((slip_o & $past(slip_i)) == $past(slip_i)));
endmodule

// File: rtl/aud_event_notify.sv
module aud_event_notify
  import aud_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    ev_i,
  input  logic [OWN_W-1:0] owner_i,
  output logic [DW-1:0]    evt_o,
  output logic             ntf_valid_o,
  output logic [DW-1:0]    ntf_word_o,
  output logic [OWN_W-1:0] ntf_addr_o
);
  logic [DW-1:0]    evt_q, ntf_word_q;
  logic [OWN_W-1:0] ntf_addr_q;
  logic             ntf_valid_q, ntf_valid_d, ev_any;

  always_comb begin
    ev_any      = |ev_i;
    ntf_valid_d = ev_any && (owner_i != NO_OWNER);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q       <= '0;
      ntf_valid_q <= 1'b0;
      ntf_word_q  <= '0;
      ntf_addr_q  <= NO_OWNER;
    end else begin
      ntf_valid_q <= ntf_valid_d;
      if (ev_any) evt_q <= ev_i;
      if (ntf_valid_d) begin
        ntf_word_q <= ev_i;
        ntf_addr_q <= owner_i;
      end
    end
  end

  assign evt_o       = evt_q;
  assign ntf_valid_o = ntf_valid_q;
  assign ntf_word_o  = ntf_word_q;
  assign ntf_addr_o  = ntf_addr_q;

  assert_evt_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_i) |=> (evt_o == $past(ev_i)));
  assert_push_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid_o |-> (ntf_addr_o != NO_OWNER));
  assert_push_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid_o |-> (ntf_word_o == evt_o));
endmodule

// File: rtl/audio_ctl_regs.sv
module audio_ctl_regs
  import aud_regs_pkg::*;
#(
  parameter logic [NUM_SRC-1:0]  SRC_CAP  = 13'h10FF,
  parameter logic [NUM_RATE-1:0] RATE_CAP = 7'h1F
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  input  logic [OWN_W-1:0]  req_cmp_i,
  input  logic [OWN_W-1:0]  req_swap_i,
  output logic              rsp_valid_o,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic [OWN_W-1:0]  rsp_old_o,
  input  logic              rx_cfg_chg_i,
  input  logic              tx_cfg_chg_i,
  input  logic [LOCK_W-1:0] lock_i,
  input  logic [LOCK_W-1:0] slip_i,
  output logic              ntf_valid_o,
  output logic [DW-1:0]     ntf_word_o,
  output logic [OWN_W-1:0]  ntf_addr_o,
  output logic              stream_en_o
);
  localparam int HALF = OWN_W / 2;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s  <= rst_s1;
    end
  end

  logic is_rd, is_wr, is_cas, cas_own, clk_wr, stream_wr, xstat_rd;
  always_comb begin
    is_rd     = req_valid_i && (req_op_i == OP_RD);
    is_wr     = req_valid_i && (req_op_i == OP_WR);
    is_cas    = req_valid_i && (req_op_i == OP_CAS);
    cas_own   = is_cas && (req_addr_i == IDX_OWN_HI);
    clk_wr    = is_wr  && (req_addr_i == IDX_CLKSEL);
    stream_wr = is_wr  && (req_addr_i == IDX_STREAM);
    xstat_rd  = is_rd  && (req_addr_i == IDX_XSTAT);
  end

  logic [OWN_W-1:0]  owner;
  logic [FLD_W-1:0]  cur_src, cur_rate;
  logic [LOCK_W-1:0] lock_q, slip_q;
  logic              any_lock_chg;
  logic [DW-1:0]     evt_q;

  aud_owner_cas u_owner (
    .clk(clk), .rst_n(rst_s), .bus_reset_i(bus_reset_i), .cas_en_i(cas_own),
    .cmp_i(req_cmp_i), .swap_i(req_swap_i), .owner_o(owner));

  aud_clk_select #(.SRC_CAP(SRC_CAP), .RATE_CAP(RATE_CAP)) u_clksel (
    .clk(clk), .rst_n(rst_s), .wr_en_i(clk_wr),
    .wr_src_i(req_wdata_i[FLD_W-1:0]), .wr_rate_i(req_wdata_i[2*FLD_W-1:FLD_W]),
    .src_o(cur_src), .rate_o(cur_rate));

  aud_ext_status u_xstat (
    .clk(clk), .rst_n(rst_s), .lock_i(lock_i), .slip_i(slip_i),
    .rd_clr_i(xstat_rd), .lock_o(lock_q), .slip_o(slip_q),
    .any_chg_o(any_lock_chg));

  logic [DW-1:0] ev_word;
  always_comb begin
    ev_word              = '0;
    ev_word[EV_RX]       = rx_cfg_chg_i;
    ev_word[EV_TX]       = tx_cfg_chg_i;
    ev_word[EV_CUR_LOCK] = src_lock(cur_src, lock_i) != src_lock(cur_src, lock_q);
    ev_word[EV_ACCEPT]   = clk_wr;
    ev_word[EV_ANY_LOCK] = any_lock_chg;
  end

  aud_event_notify u_notify (
    .clk(clk), .rst_n(rst_s), .ev_i(ev_word), .owner_i(owner), .evt_o(evt_q),
    .ntf_valid_o(ntf_valid_o), .ntf_word_o(ntf_word_o), .ntf_addr_o(ntf_addr_o));

  // stream enable
  logic stream_q, stream_d, stream_ce;
  always_comb begin
    stream_ce = bus_reset_i || stream_wr;
    stream_d  = bus_reset_i ? 1'b0 : (|req_wdata_i);
  end
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)         stream_q <= 1'b0;
    else if (stream_ce) stream_q <= stream_d;
  end
  assign stream_en_o = stream_q;

  // read mux and response
  logic [DW-1:0]    rdata_d;
  logic [OWN_W-1:0] old_d;
  always_comb begin
    rdata_d = '0;
    if (is_rd) begin
      case (req_addr_i)
        IDX_OWN_HI: rdata_d = owner[OWN_W-1:HALF];
        IDX_OWN_LO: rdata_d = owner[HALF-1:0];
        IDX_EVENT:  rdata_d = evt_q;
        IDX_CLKSEL: rdata_d = {{(DW-2*FLD_W){1'b0}}, cur_rate, cur_src};
        IDX_STREAM: rdata_d = {{(DW-1){1'b0}}, stream_q};
        IDX_XSTAT: begin
          rdata_d[LOCK_W-1:0]                 = lock_q;
          rdata_d[SLIP_LSB+LOCK_W-1:SLIP_LSB] = slip_q;
        end
        default:    rdata_d = '0;
      endcase
    end
    old_d = cas_own ? owner : '0;
  end

  logic             rsp_valid_q;
  logic [DW-1:0]    rsp_rdata_q;
  logic [OWN_W-1:0] rsp_old_q;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      rsp_old_q   <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      if (req_valid_i) begin
        rsp_rdata_q <= rdata_d;
        rsp_old_q   <= old_d;
      end
    end
  end
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign rsp_old_o   = rsp_old_q;

  assert_accept_evt_R6: assert property (@(posedge clk) disable iff (!rst_s)
    clk_wr |=> evt_q[EV_ACCEPT]);
  assert_stream_busrst_R10: assert property (@(posedge clk) disable iff (!rst_s)
    bus_reset_i |=> !stream_en_o);
  assert_cas_old_R2: assert property (@(posedge clk) disable iff (!rst_s)
    cas_own |=> (rsp_old_o == $past(owner)));
endmodule

// File: tb/audio_ctl_regs_tb.sv
module audio_ctl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_reset_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_op_i = 2'd0;
  logic [5:0]  req_addr_i = 6'd0;
  logic [31:0] req_wdata_i = 32'd0;
  logic [63:0] req_cmp_i = 64'd0;
  logic [63:0] req_swap_i = 64'd0;
  logic        rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic [63:0] rsp_old_o;
  logic        rx_cfg_chg_i = 1'b0;
  logic        tx_cfg_chg_i = 1'b0;
  logic [10:0] lock_i = 11'd0;
  logic [10:0] slip_i = 11'd0;
  logic        ntf_valid_o;
  logic [31:0] ntf_word_o;
  logic [63:0] ntf_addr_o;
  logic        stream_en_o;

  audio_ctl_regs u_dut (.*);

  always #5 clk = ~clk;

  localparam logic [63:0] NOBODY = 64'hFFFF_0000_0000_0000;
  localparam logic [63:0] HOST   = 64'h0001_0000_1234_5678;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rd;
  logic [63:0] old;
  logic        nv;
  logic [31:0] nw;
  logic [63:0] na;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one request; caller sits on a negative edge
  task automatic xact(input logic [1:0] op, input logic [5:0] a, input logic [31:0] wd,
                      input logic [63:0] c, input logic [63:0] s);
    req_valid_i = 1'b1; req_op_i = op; req_addr_i = a;
    req_wdata_i = wd; req_cmp_i = c; req_swap_i = s;
    @(posedge clk); @(negedge clk);
    rd = rsp_rdata_o; old = rsp_old_o; nv = ntf_valid_o; nw = ntf_word_o; na = ntf_addr_o;
    req_valid_i = 1'b0;
  endtask

  task automatic rdq(input logic [5:0] a);
    xact(2'd0, a, 32'd0, 64'd0, 64'd0);
  endtask

  task automatic wrq(input logic [5:0] a, input logic [31:0] d);
    xact(2'd1, a, d, 64'd0, 64'd0);
  endtask

  task automatic pulse(input logic rx, input logic tx, input logic [10:0] lk, input logic [10:0] sl);
    rx_cfg_chg_i = rx; tx_cfg_chg_i = tx; lock_i = lk; slip_i = sl;
    @(posedge clk); @(negedge clk);
    nv = ntf_valid_o; nw = ntf_word_o; na = ntf_addr_o;
    rx_cfg_chg_i = 1'b0; tx_cfg_chg_i = 1'b0; slip_i = '0;
  endtask

  task automatic t_reset;
    rdq(6'd0); chk("R1 owner hi", rd, 32'hFFFF0000);
    rdq(6'd1); chk("R1 owner lo", rd, 32'h0);
    rdq(6'd2); chk("R1 event", rd, 32'h0);
    rdq(6'd3); chk("R1 clksel", rd, 32'h020C);
    rdq(6'd4); chk("R1 stream", rd, 32'h0);
    chk("R1 stream pin", stream_en_o, 1'b0);
  endtask

  task automatic t_unowned_event;
    pulse(1'b1, 1'b0, 11'd0, 11'd0);
    chk("R5 no push unowned", nv, 1'b0);
    rdq(6'd2); chk("R4 rx event latched", rd, 32'h1);
  endtask

  task automatic t_cas;
    xact(2'd2, 6'd0, 32'd0, 64'd0, HOST);
    chk("R2 old on miss", old, NOBODY);
    rdq(6'd0); chk("R2 miss keeps owner", rd, 32'hFFFF0000);
    xact(2'd2, 6'd0, 32'd0, NOBODY, HOST);
    chk("R2 old on hit", old, NOBODY);
    rdq(6'd0); chk("R2 hi stored", rd, 32'h00010000);
    rdq(6'd1); chk("R2 lo stored", rd, 32'h12345678);
  endtask

  task automatic t_readonly;
    wrq(6'd0, 32'hDEAD0000); wrq(6'd1, 32'h0);
    rdq(6'd0); chk("R3 hi unchanged", rd, 32'h00010000);
    rdq(6'd1); chk("R3 lo unchanged", rd, 32'h12345678);
    wrq(6'd2, 32'hFF); rdq(6'd2); chk("R11 event not writable", rd, 32'h1);
    wrq(6'd5, 32'hFFFFFFFF); rdq(6'd5); chk("R11 xstat not writable", rd, 32'h0);
    rdq(6'd9); chk("R11 unmapped", rd, 32'h0);
    rdq(6'd63); chk("R11 unmapped top", rd, 32'h0);
  endtask

  task automatic t_push;
    pulse(1'b0, 1'b1, 11'd0, 11'd0);
    chk("R5 push valid", nv, 1'b1);
    chk("R5 push word", nw, 32'h2);
    chk("R5 push addr", na, HOST);
    rdq(6'd2); chk("R4 overwrite drops rx", rd, 32'h2);
    pulse(1'b1, 1'b1, 11'd0, 11'd0);
    chk("R4 both cfg bits", nw, 32'h3);
  endtask

  task automatic t_clksel;
    wrq(6'd3, 32'h0401);
    chk("R6 accept push", nv, 1'b1); chk("R6 accept word", nw, 32'h20);
    rdq(6'd3); chk("R6 readback", rd, 32'h0401);
    wrq(6'd3, 32'h0109);
    chk("R7 accept on bad src", nw, 32'h20);
    rdq(6'd3); chk("R7 src falls to internal", rd, 32'h010C);
    wrq(6'd3, 32'h0502);
    rdq(6'd3); chk("R7 rate kept", rd, 32'h0102);
    rdq(6'd2); chk("R7 accept latched", rd, 32'h20);
  endtask

  task automatic t_lock;
    pulse(1'b0, 1'b0, 11'h004, 11'd0);
    chk("R8 cur source change", nw, 32'h50);
    rdq(6'd5); chk("R8 live lock", rd, 32'h4);
    pulse(1'b0, 1'b0, 11'h084, 11'd0);
    chk("R8 other source change", nw, 32'h40);
    @(posedge clk); @(negedge clk);
    chk("R8 steady no push", ntf_valid_o, 1'b0);
  endtask

  task automatic t_slip;
    pulse(1'b0, 1'b0, 11'h084, 11'h008);
    chk("R9 slip no push", nv, 1'b0);
    repeat (3) @(negedge clk);
    rdq(6'd5); chk("R9 slip sticky", rd, 32'h0008_0084);
    rdq(6'd5); chk("R9 slip cleared", rd, 32'h0000_0084);
    rdq(6'd2); chk("R9 no event", rd, 32'h40);
  endtask

  task automatic t_stream;
    wrq(6'd4, 32'h5); rdq(6'd4); chk("R10 nonzero starts", rd, 32'h1);
    chk("R10 pin on", stream_en_o, 1'b1);
    wrq(6'd4, 32'h0); rdq(6'd4); chk("R10 zero stops", rd, 32'h0);
    wrq(6'd4, 32'h7);
    bus_reset_i = 1'b1; @(posedge clk); @(negedge clk); bus_reset_i = 1'b0;
    chk("R10 bus reset stops", stream_en_o, 1'b0);
    rdq(6'd0); chk("R1 bus reset owner hi", rd, 32'hFFFF0000);
    rdq(6'd1); chk("R1 bus reset owner lo", rd, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_unowned_event;
    t_cas;
    t_readonly;
    t_push;
    t_clksel;
    t_lock;
    t_slip;
    t_stream;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule